// File: doc/BRIEF.md
# Miss-Clustering Core-Switch Scheduler

This block is a hardware policy engine that decides which of two cores runs a single thread. One core is wide and built for instruction-level parallelism. The other is narrower and faster, and it is fitted with a technique for overlapping long-latency misses. The engine watches two things: how many instructions retire each cycle, and a one-cycle pulse for each second-level cache miss. From these it decides when misses are bunching together and execution should move to the miss-overlapping core. It also decides when the bunching has ended and execution should move back to the wide core.

The move to the miss-overlapping core is eager. While the thread runs on the wide core, retired instructions are grouped into back-to-back windows of fixed length, and misses are counted inside each window. The switch begins in the very cycle the count reaches a threshold. That threshold is the window length times a miss rate.

The move back is lazy. After arrival, a short stay window must see at least one miss. If it does, execution continues for a longer extension window, and the same test is applied when that window ends. If a window ends with no miss seen, execution returns to the wide core.

Every switch runs the same sequence: fetch is stalled, the engine waits until the pipeline reports it is empty, a register copy of fixed length runs, and then a one-cycle resume pulse marks the start of execution on the new core.

Top module: `core_switch_sched`

## Requirements
- R1: After reset, `core_sel` is 0 (wide core), and `fetch_stall`, `copy_busy` and `resume` are all 0.
- R2: On the wide core, with `sched_en` high, `retire_cnt` is summed into back-to-back windows of WIN_LEN instructions. When the misses counted in the current window reach MISS_THRESH = WIN_LEN*RATE_NUM/RATE_DEN (at least 1), `fetch_stall` is 1 from the next cycle on. A miss pulse in the cycle where a window closes counts toward the window that is closing.
- R3: A wide-core window that closes with fewer than MISS_THRESH misses clears the miss count, so misses split across two windows never trigger a switch. Instructions past the window boundary carry into the next window.
- R4: Once `fetch_stall` is 1, it stays 1 and `copy_busy` stays 0 for as long as `pipe_empty` is sampled low. The cycle after `pipe_empty` is sampled high, `copy_busy` is 1.
- R5: `copy_busy` stays high for exactly COPY_CYCLES cycles. In the next cycle, `resume` is 1 for one cycle, `fetch_stall` and `copy_busy` are 0, and `core_sel` shows the target core (1 = miss-overlapping core). `core_sel` changes only in the cycle `resume` is 1.
- R6: On the miss-overlapping core, if the first STAY_LEN retired instructions bring no miss, `fetch_stall` rises in the cycle after the count reaches STAY_LEN, and the switch then leads back to `core_sel` = 0.
- R7: A miss inside the stay window, or in the cycle it closes, extends the run by a window of EXT_LEN instructions. At the end of that window the same test is applied: a miss seen extends again, and no miss starts the switch back.
- R8: Miss pulses and retire counts that arrive during drain or copy are ignored, and every window count starts from zero in the cycle `resume` is high.
- R9: While `sched_en` is 0 and no switch is under way, no switch is requested: `fetch_stall` stays 0, `core_sel` holds its value, and the window counts are held at zero.
- R10: The window lengths, the rate that sets the threshold, the copy delay and the width of the retire count are parameters. Defaults: WIN_LEN 3000, rate 1/1000 (threshold 3), STAY_LEN 700, EXT_LEN 3000, COPY_CYCLES 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_en | input | 1 | High to let the scheduler move the thread; low holds the current core |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| miss_pulse | input | 1 | One-cycle pulse per second-level cache miss |
| pipe_empty | input | 1 | High when every in-flight instruction has retired |
| fetch_stall | output | 1 | Stall request to the fetch engine during drain and copy |
| core_sel | output | 1 | Active core: 0 wide core, 1 miss-overlapping core |
| copy_busy | output | 1 | High while the register copy runs |
| resume | output | 1 | One-cycle pulse when execution restarts on the selected core |

## Verification
The bench builds the block with WIN_LEN 40 and a rate of 1/10, which gives a threshold of 4. It also uses STAY_LEN 12, EXT_LEN 30, COPY_CYCLES 6 and a 3-bit retire count. With these values, many window closings, several stay and extension decisions, and dozens of full round trips between the cores fit into a few thousand cycles. The short windows also make the boundary cases easy to reach within each run: threshold hits on the exact closing cycle, carry-over of the instruction count past a boundary, and misses that land during drain or copy.

// File: rtl/core_switch_sched.sv
module core_switch_sched #(
  parameter int WIN_LEN     = 3000,
  parameter int RATE_NUM    = 1,
  parameter int RATE_DEN    = 1000,
  parameter int STAY_LEN    = 700,
  parameter int EXT_LEN     = 3000,
  parameter int COPY_CYCLES = 100,
  parameter int RET_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sched_en,
  input  logic [RET_W-1:0] retire_cnt,
  input  logic             miss_pulse,
  input  logic             pipe_empty,
  output logic             fetch_stall,
  output logic             core_sel,
  output logic             copy_busy,
  output logic             resume
);

  localparam int RAW_THR     = WIN_LEN * RATE_NUM / RATE_DEN;
  localparam int MISS_THRESH = (RAW_THR < 1) ? 1 : RAW_THR;
  localparam int CW          = $clog2(WIN_LEN + STAY_LEN + EXT_LEN + (1 << RET_W) + 1);
  localparam int MW          = $clog2(MISS_THRESH + 2);
  localparam int KW          = $clog2(COPY_CYCLES + 1);

  typedef enum logic [1:0] {
    S_WIDE  = 2'd0,
    S_MLP   = 2'd1,
    S_DRAIN = 2'd2,
    S_COPY  = 2'd3
  } state_t;

  state_t        st;
  logic          tgt;
  logic [CW-1:0] icnt;
  logic [MW-1:0] mcnt;
  logic          seen;
  logic          ext_ph;
  logic [KW-1:0] ccnt;

  logic [CW-1:0] isum;
  logic [CW-1:0] lim;
  logic [MW-1:0] msum;
  logic          thr_hit;

  assign isum    = icnt + CW'(retire_cnt);
  assign lim     = ext_ph ? CW'(EXT_LEN) : CW'(STAY_LEN);
  assign msum    = mcnt + MW'(miss_pulse);
  assign thr_hit = msum >= MW'(MISS_THRESH);

  assign fetch_stall = (st == S_DRAIN) || (st == S_COPY);
  assign copy_busy   = (st == S_COPY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_WIDE;
      tgt      <= 1'b0;
      icnt     <= '0;
      mcnt     <= '0;
      seen     <= 1'b0;
      ext_ph   <= 1'b0;
      ccnt     <= '0;
      core_sel <= 1'b0;
      resume   <= 1'b0;
    end else begin
      resume <= 1'b0;
      case (st)
        S_WIDE: begin
          if (!sched_en) begin
            icnt <= '0;
            mcnt <= '0;
          end else if (thr_hit) begin
            st  <= S_DRAIN;
            tgt <= 1'b1;
          end else if (isum >= CW'(WIN_LEN)) begin
            icnt <= isum - CW'(WIN_LEN);
            mcnt <= '0;
          end else begin
            icnt <= isum;
            mcnt <= msum;
          end
        end
        S_MLP: begin
          if (!sched_en) begin
            icnt   <= '0;
            seen   <= 1'b0;
            ext_ph <= 1'b0;
          end else if (isum >= lim) begin
            if (seen || miss_pulse) begin
              ext_ph <= 1'b1;
              seen   <= 1'b0;
              icnt   <= isum - lim;
            end else begin
              st  <= S_DRAIN;
              tgt <= 1'b0;
            end
          end else begin
            icnt <= isum;
            seen <= seen | miss_pulse;
          end
        end
        S_DRAIN: begin
          if (pipe_empty) begin
            st   <= S_COPY;
            ccnt <= '0;
          end
        end
        default: begin
          if (ccnt == KW'(COPY_CYCLES - 1)) begin
            st       <= tgt ? S_MLP : S_WIDE;
            core_sel <= tgt;
            resume   <= 1'b1;
            icnt     <= '0;
            mcnt     <= '0;
            seen     <= 1'b0;
            ext_ph   <= 1'b0;
          end else begin
            ccnt <= ccnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R4
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && !copy_busy && !pipe_empty) |=> (fetch_stall && !copy_busy));

  // R4
  copy_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(copy_busy) |-> $past(pipe_empty));

  // R5
  resume_after_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!fetch_stall && $past(copy_busy)));

  // R5
  copy_end_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(copy_busy) |-> resume);

  // R5
  sel_only_on_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_sel) |-> resume);

  // R9
  disabled_no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sched_en && !fetch_stall) |=> (!fetch_stall && $stable(core_sel)));

endmodule

// File: tb/core_switch_sched_tb.sv
module core_switch_sched_tb;
  localparam int WIN   = 40;
  localparam int RN    = 1;
  localparam int RD    = 10;
  localparam int THR   = WIN * RN / RD;
  localparam int STAY  = 12;
  localparam int EXT   = 30;
  localparam int COPY  = 6;
  localparam int RW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sched_en = 1'b0;
  logic [RW-1:0] retire_cnt = '0;
  logic miss_pulse = 1'b0;
  logic pipe_empty = 1'b0;
  logic fetch_stall, core_sel, copy_busy, resume;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  core_switch_sched #(
    .WIN_LEN(WIN), .RATE_NUM(RN), .RATE_DEN(RD), .STAY_LEN(STAY),
    .EXT_LEN(EXT), .COPY_CYCLES(COPY), .RET_W(RW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .retire_cnt(retire_cnt),
    .miss_pulse(miss_pulse), .pipe_empty(pipe_empty), .fetch_stall(fetch_stall),
    .core_sel(core_sel), .copy_busy(copy_busy), .resume(resume)
  );

  // expected-behaviour model built from the requirements
  int m_st, m_ic, m_mc, m_cc, m_tgt;
  bit m_seen, m_ext, m_sel, m_res;

  function automatic void model_reset();
    m_st = 0; m_ic = 0; m_mc = 0; m_cc = 0; m_tgt = 0;
    m_seen = 0; m_ext = 0; m_sel = 0; m_res = 0;
  endfunction

  function automatic void model_step(bit en, int ret, bit miss, bit pe);
    int lim;
    m_res = 0;
    case (m_st)
      0: begin
        if (!en) begin m_ic = 0; m_mc = 0; end
        else if (m_mc + miss >= THR) begin m_st = 2; m_tgt = 1; end
        else if (m_ic + ret >= WIN) begin m_ic = m_ic + ret - WIN; m_mc = 0; end
        else begin m_ic = m_ic + ret; m_mc = m_mc + miss; end
      end
      1: begin
        lim = m_ext ? EXT : STAY;
        if (!en) begin m_ic = 0; m_seen = 0; m_ext = 0; end
        else if (m_ic + ret >= lim) begin
          if (m_seen || miss) begin m_ext = 1; m_seen = 0; m_ic = m_ic + ret - lim; end
          else begin m_st = 2; m_tgt = 0; end
        end else begin m_ic = m_ic + ret; m_seen = m_seen | miss; end
      end
      2: if (pe) begin m_st = 3; m_cc = 0; end
      default: begin
        if (m_cc == COPY - 1) begin
          m_st = m_tgt; m_sel = m_tgt[0]; m_res = 1;
          m_ic = 0; m_mc = 0; m_seen = 0; m_ext = 0;
        end else m_cc = m_cc + 1;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step(sched_en, int'(retire_cnt), miss_pulse, pipe_empty);
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model(string tag);
    chk({tag, " fetch_stall"}, int'(fetch_stall), int'(m_st >= 2));
    chk({tag, " copy_busy"}, int'(copy_busy), int'(m_st == 3));
    chk({tag, " core_sel"}, int'(core_sel), int'(m_sel));
    chk({tag, " resume"}, int'(resume), int'(m_res));
  endtask

  // drive inputs at a falling edge, advance one cycle, compare at the next falling edge
  task automatic step(bit en, int ret, bit miss, bit pe, string tag);
    sched_en = en; retire_cnt = RW'(ret); miss_pulse = miss; pipe_empty = pe;
    @(negedge clk);
    cmp_model(tag);
  endtask

  task automatic finish_switch(string tag);
    int n;
    step(1, 0, 1, 1, tag);
    n = 1;
    while (copy_busy && n < 50) begin
      step(1, 3, 1, 0, tag);
      n++;
    end
    chk({tag, " resume pulse"}, int'(resume), 1);
    // R5
    chk("R5 copy length", n - 1, COPY);
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1
    chk("R1 core_sel", int'(core_sel), 0);
    chk("R1 fetch_stall", int'(fetch_stall), 0);
    chk("R1 copy_busy", int'(copy_busy), 0);
    chk("R1 resume", int'(resume), 0);
    rst_n = 1'b1;

    // R3: misses spread over two windows, three per window
    for (int i = 1; i <= 80; i++)
      step(1, 1, (i % 5 == 0) && ((i <= 15) || (i >= 45 && i <= 55)), 0, "R3");
    chk("R3 no switch", int'(fetch_stall), 0);

    // R2: threshold reached within one window
    for (int i = 1; i <= 3; i++) step(1, 1, 1, 0, "R2");
    chk("R2 before threshold", int'(fetch_stall), 0);
    step(1, 1, 1, 0, "R2");
    chk("R2 stall on threshold", int'(fetch_stall), 1);

    // R4: drain waits for an empty pipeline; misses ignored meanwhile (R8)
    for (int i = 0; i < 5; i++) step(1, 2, 1, 0, "R4");
    chk("R4 still draining", int'(copy_busy), 0);
    chk("R4 stall held", int'(fetch_stall), 1);
    finish_switch("R5");
    chk("R5 target sel", int'(core_sel), 1);

    // R6 + R8: no miss in stay window, misses during copy must not count
    for (int i = 1; i <= STAY - 1; i++) step(1, 1, 0, 0, "R6");
    chk("R8 copy misses ignored", int'(fetch_stall), 0);
    step(1, 1, 0, 0, "R6");
    chk("R6 return on quiet stay", int'(fetch_stall), 1);
    finish_switch("R6");
    chk("R6 back on wide core", int'(core_sel), 0);

    // R7: miss inside stay window extends
    for (int i = 0; i < THR; i++) step(1, 1, 1, 0, "R7");
    finish_switch("R7");
    for (int i = 1; i <= STAY; i++) step(1, 1, i == 3, 0, "R7");
    step(1, 1, 0, 0, "R7");
    chk("R7 extended", int'(fetch_stall), 0);
    for (int i = 2; i <= EXT - 1; i++) step(1, 1, 0, 0, "R7");
    chk("R7 before extension end", int'(fetch_stall), 0);
    step(1, 1, 0, 0, "R7");
    chk("R7 quiet extension returns", int'(fetch_stall), 1);
    finish_switch("R7");

    // R9: scheduler disabled
    for (int i = 0; i < 100; i++) begin
      step(0, 4, 1, 1, "R9");
      chk("R9 no stall", int'(fetch_stall), 0);
      chk("R9 sel held", int'(core_sel), 0);
    end

    // R10: random traffic against the model at the reduced parameters
    for (int i = 0; i < 6000; i++)
      step(($urandom % 16) != 0, $urandom % 5, ($urandom % 8) == 0,
           ($urandom % 3) == 0, "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule